// File: doc/BRIEF.md
# Biphase-Mark Digital Audio Transmitter with Output Selector

This block turns a stereo PCM stream into a consumer-format serial digital audio line signal. A master clock at 256 times the frame rate drives it, so at a 48 kHz frame rate each frame lasts 256 clocks. Every frame carries two 32-slot subframes: left first, then right. Each slot becomes two half-cells of biphase-mark code, and one half-cell lasts two clocks. A subframe opens with a sync pattern that breaks the coding rule. That pattern marks block starts, other left subframes and right subframes. A 192-frame block also carries a channel-status bit sequence, one bit per frame.

Samples arrive as a left/right pair on a parallel port with a one-cycle valid strobe. A configuration input picks between a 24-bit word and a 16-bit word. A 16-bit word is placed at the top of the audio field and zeros fill the bits below it. A two-bit selector chooses what drives the single output pin. Code 00 selects the encoded stream. Every other code passes a raw serial input straight through. While reset is asserted the pin is held low.

Top module: `spdif_tx_mux`

## Requirements
- R1: When `sel` is 2'b00 the pin carries the encoded stream. For 2'b01, 2'b10 and 2'b11 the pin equals `bypass_in` in the same cycle, with no register in the path.
- R2: While `rst` is high, `tx_out` is low whatever `sel` and `bypass_in` are.
- R3: Each half-cell holds its level for exactly two clocks, and a frame is 128 half-cells. Slots 4 to 31 are biphase-mark coded. The level always flips at the start of a slot, and it flips again mid-slot only for a 1.
- R4: Slots 0 to 3 carry an 8-half-cell sync pattern, written here in time order for a preceding level of 0: block-start `11101000`, other-left `11100010`, right `11100100`. The pattern is inverted when the preceding level is 1. The block-start pattern opens the left subframe of frame 0 of each 192-frame block. Other left subframes use the other-left pattern, and right subframes use the right pattern.
- R5: In 24-bit mode, sample bit i is sent in slot 4+i for i = 0..23. This puts the lowest sample bit first.
- R6: In 16-bit mode, slots 4 to 11 are 0 and sample bit i (i = 0..15) is sent in slot 12+i.
- R7: Slot 28 (validity) and slot 29 (user) are always 0.
- R8: Slot 30 of both subframes of frame n of a block carries `cs_bits[n]`. The `cs_bits` input is captured at the start of each block.
- R9: Slot 31 is set so that slots 4 to 31 hold an even number of ones.
- R10: A pair captured on `sample_valid` is sent in the next frame that starts after it is captured. The level of `fmt16` is sampled at each frame start. After reset, the first frame begins on the first clock edge and carries zero samples in 24-bit mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock, 256 times the frame rate |
| rst | input | 1 | Synchronous active-high reset; also forces the pin low |
| sample_valid | input | 1 | One-cycle strobe that captures a sample pair |
| sample_left | input | 24 | Left sample word (bits 15:0 used in 16-bit mode) |
| sample_right | input | 24 | Right sample word (bits 15:0 used in 16-bit mode) |
| fmt16 | input | 1 | 1 selects the 16-bit word format, 0 the 24-bit one |
| cs_bits | input | 192 | Channel-status sequence; bit n goes out in frame n of a block |
| sel | input | 2 | Output select; 2'b00 picks the encoder, other codes pick bypass |
| bypass_in | input | 1 | Raw serial signal passed to the pin when bypass is selected |
| tx_out | output | 1 | Output pin |

## Verification
The first half-cell after reset release is due on the first clock edge. Half-cell k of a frame is therefore stable after edges 2k+1 and 2k+2. The bench samples it at both falling edges that follow those two edges, which also checks the two-clock width. A pair strobed during frame n is expected only in frame n+1, so the bench moves its expected values forward one frame at a time. Slot fields are recovered by decoding the captured half-cells against the preceding level. Bypass and reset effects are combinational, so the bench checks them one nanosecond after it changes the input, away from any clock edge.

// File: rtl/spdif_tx_pkg.sv
package spdif_tx_pkg;

    localparam int SLOTS_PER_SUB   = 32;
    localparam int HALVES_PER_FRM  = 4 * SLOTS_PER_SUB;
    localparam int HC_W            = $clog2(HALVES_PER_FRM);
    localparam int WORD_W          = 24;

    typedef enum logic [1:0] {
        SYNC_BLOCK = 2'd0,
        SYNC_LEFT  = 2'd1,
        SYNC_RIGHT = 2'd2
    } sync_kind_t;

    typedef struct packed {
        logic              fmt16;
        logic [WORD_W-1:0] left;
        logic [WORD_W-1:0] right;
    } pcm_pair_t;

    // Sync pattern for preceding level 0, bit 7 is sent first.
    function automatic logic [7:0] sync_pattern(sync_kind_t k);
        case (k)
            SYNC_BLOCK: return 8'b1110_1000;
            SYNC_LEFT:  return 8'b1110_0010;
            default:    return 8'b1110_0100;
        endcase
    endfunction

    // Field bit i goes to slot 4+i.
    function automatic logic [WORD_W-1:0] place_word(logic [WORD_W-1:0] s, logic fmt16);
        return fmt16 ? {s[15:0], 8'h00} : s;
    endfunction

endpackage

// File: rtl/spdif_frame_timer.sv
module spdif_frame_timer
    import spdif_tx_pkg::*;
#(
    parameter int CLK_PER_HALF = 2,
    parameter int FRAMES       = 192
) (
    input  logic                       clk,
    input  logic                       rst,
    output logic                       tick,
    output logic [HC_W-1:0]            hc_next,
    output logic [$clog2(FRAMES)-1:0]  frame_q,
    output logic [$clog2(FRAMES)-1:0]  frame_next
);
    localparam int PW = (CLK_PER_HALF > 1) ? $clog2(CLK_PER_HALF) : 1;
    localparam int FW = $clog2(FRAMES);
    localparam logic [PW-1:0]   PH_LAST  = PW'(CLK_PER_HALF - 1);
    localparam logic [HC_W-1:0] HC_LAST  = HC_W'(HALVES_PER_FRM - 1);
    localparam logic [FW-1:0]   FRM_LAST = FW'(FRAMES - 1);

    logic [PW-1:0]   phase_q;
    logic [HC_W-1:0] hc_q;

    assign tick       = (phase_q == PH_LAST);
    assign hc_next    = hc_q + 1'b1;
    assign frame_next = (hc_q != HC_LAST) ? frame_q :
                        (frame_q == FRM_LAST) ? '0 : frame_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_LAST;
            hc_q    <= HC_LAST;
            frame_q <= FRM_LAST;
        end else begin
            phase_q <= tick ? '0 : phase_q + 1'b1;
            if (tick) begin
                hc_q    <= hc_next;
                frame_q <= frame_next;
            end
        end
    end
endmodule

// File: rtl/spdif_subframe_build.sv
module spdif_subframe_build
    import spdif_tx_pkg::*;
(
    input  pcm_pair_t   pcm,
    input  logic        right_sub,
    input  logic        block_start,
    input  logic        cs_bit,
    output logic [31:0] word,
    output sync_kind_t  kind
);
    logic [WORD_W-1:0] field;

    always_comb begin
        field     = place_word(right_sub ? pcm.right : pcm.left, pcm.fmt16);
        word      = '0;
        word[27:4] = field;
        word[28]  = 1'b0;
        word[29]  = 1'b0;
        word[30]  = cs_bit;
        word[31]  = ^word[30:4];
        if (right_sub)        kind = SYNC_RIGHT;
        else if (block_start) kind = SYNC_BLOCK;
        else                  kind = SYNC_LEFT;
    end
endmodule

// File: rtl/spdif_bmc_line.sv
module spdif_bmc_line
    import spdif_tx_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            tick,
    input  logic [HC_W-1:0] hc_next,
    input  logic [31:0]     word,
    input  sync_kind_t      kind,
    output logic            line
);
    logic       line_q, ref_q, ref_use, nxt;
    logic [5:0] k;
    logic [4:0] slot;
    logic [7:0] pat;

    assign k       = hc_next[5:0];
    assign slot    = k[5:1];
    assign pat     = sync_pattern(kind);
    assign ref_use = (k == 6'd0) ? line_q : ref_q;

    always_comb begin
        if (k < 6'd8)      nxt = pat[~k[2:0]] ^ ref_use;
        else if (!k[0])    nxt = ~line_q;
        else               nxt = word[slot] ? ~line_q : line_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q <= 1'b0;
            ref_q  <= 1'b0;
        end else if (tick) begin
            line_q <= nxt;
            if (k == 6'd0) ref_q <= line_q;
        end
    end

    assign line = line_q;
endmodule

// File: rtl/spdif_tx_mux.sv
module spdif_tx_mux
    import spdif_tx_pkg::*;
#(
    parameter int CLK_PER_HALF = 2,
    parameter int FRAMES       = 192
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sample_valid,
    input  logic [23:0]         sample_left,
    input  logic [23:0]         sample_right,
    input  logic                fmt16,
    input  logic [FRAMES-1:0]   cs_bits,
    input  logic [1:0]          sel,
    input  logic                bypass_in,
    output logic                tx_out
);
    localparam int FW = $clog2(FRAMES);

    logic            tick, frame_start, line;
    logic [HC_W-1:0] hc_next;
    logic [FW-1:0]   frame_q, frame_next;
    pcm_pair_t       hold_q, act_q;
    logic [FRAMES-1:0] cs_q;
    logic [31:0]     word;
    sync_kind_t      kind;

    spdif_frame_timer #(.CLK_PER_HALF(CLK_PER_HALF), .FRAMES(FRAMES)) u_tim (
        .clk(clk), .rst(rst), .tick(tick), .hc_next(hc_next),
        .frame_q(frame_q), .frame_next(frame_next)
    );

    assign frame_start = tick && (hc_next == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            act_q  <= '0;
            cs_q   <= '0;
        end else begin
            if (sample_valid) begin
                hold_q.left  <= sample_left;
                hold_q.right <= sample_right;
            end
            if (frame_start) begin
                act_q.fmt16 <= fmt16;
                act_q.left  <= hold_q.left;
                act_q.right <= hold_q.right;
                cs_q        <= (frame_next == '0) ? cs_bits : (cs_q >> 1);
            end
        end
    end

    spdif_subframe_build u_build (
        .pcm(act_q), .right_sub(hc_next[6]), .block_start(frame_next == '0),
        .cs_bit(cs_q[0]), .word(word), .kind(kind)
    );

    spdif_bmc_line u_line (
        .clk(clk), .rst(rst), .tick(tick), .hc_next(hc_next),
        .word(word), .kind(kind), .line(line)
    );

    assign tx_out = rst ? 1'b0 : ((sel == 2'b00) ? line : bypass_in);
endmodule

// File: rtl/spdif_tx_mux_chk.sv
module spdif_tx_mux_chk
    import spdif_tx_pkg::*;
#(
    parameter int FRAMES = 192
) (
    input logic                      clk,
    input logic                      rst,
    input logic [1:0]                sel,
    input logic                      bypass_in,
    input logic                      tx_out,
    input logic                      tick,
    input logic                      line,
    input logic [HC_W-1:0]           hc_next,
    input logic [$clog2(FRAMES)-1:0] frame_q
);
    a_r2_low_in_reset: assert property (@(posedge clk) rst |-> !tx_out);

    a_r1_bypass_follow: assert property (@(posedge clk) disable iff (rst)
        (sel != 2'b00) |-> (tx_out == bypass_in));

    a_r3_hold_between_ticks: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(line));

    a_r3_slot_edge: assert property (@(posedge clk) disable iff (rst)
        (tick && hc_next[5:1] >= 5'd4 && !hc_next[0]) |=> (line != $past(line)));

    a_r4_sync_flip: assert property (@(posedge clk) disable iff (rst)
        (tick && hc_next[5:0] == 6'd0) |=> (line != $past(line)));

    a_r8_frame_in_block: assert property (@(posedge clk) disable iff (rst)
        frame_q < FRAMES);
endmodule

bind spdif_tx_mux spdif_tx_mux_chk #(.FRAMES(FRAMES)) u_chk (
    .clk(clk), .rst(rst), .sel(sel), .bypass_in(bypass_in), .tx_out(tx_out),
    .tick(tick), .line(line), .hc_next(hc_next), .frame_q(frame_q)
);

// File: tb/spdif_tx_mux_tb.sv
`timescale 1ns/1ps
module spdif_tx_mux_tb;
    localparam int FRAMES = 192;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               sample_valid = 1'b0;
    logic [23:0]        sample_left = '0, sample_right = '0;
    logic               fmt16 = 1'b0;
    logic [FRAMES-1:0]  cs_bits;
    logic [1:0]         sel = 2'b00;
    logic               bypass_in = 1'b1;
    logic               tx_out;

    int checks = 0, errors = 0;
    logic [127:0] halves;
    logic         prev_lvl;
    bit           done = 0;

    always #2.5 clk = ~clk;

    spdif_tx_mux u_dut (
        .clk(clk), .rst(rst), .sample_valid(sample_valid), .sample_left(sample_left),
        .sample_right(sample_right), .fmt16(fmt16), .cs_bits(cs_bits), .sel(sel),
        .bypass_in(bypass_in), .tx_out(tx_out)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Capture one frame of half-cells; optionally strobe a new pair for the next frame.
    task automatic capture_frame(input bit push, input logic [23:0] pl, input logic [23:0] pr,
                                 input bit pf);
        int bad = 0;
        for (int k = 0; k < 128; k++) begin
            logic s0, s1;
            @(negedge clk); s0 = tx_out;
            if (push && k == 0) begin
                sample_valid = 1'b1; sample_left = pl; sample_right = pr; fmt16 = pf;
            end
            @(negedge clk); s1 = tx_out;
            sample_valid = 1'b0;
            if (s0 != s1) bad++;
            halves[k] = s0;
        end
        chk(bad == 0, "R3", "half-cells not two clocks wide", bad, 0);
    endtask

    task automatic decode_check(input int n, input logic [23:0] l, input logic [23:0] r,
                                input bit f);
        for (int sub = 0; sub < 2; sub++) begin
            logic [7:0]  got, exp_pat;
            logic [31:0] w;
            logic [23:0] s, field;
            logic        p, h0, h1;
            int          bmc_bad = 0;
            p = prev_lvl;
            exp_pat = (sub == 1) ? 8'b1110_0100 : (n == 0) ? 8'b1110_1000 : 8'b1110_0010;
            for (int i = 0; i < 8; i++) got[7-i] = halves[sub*64+i] ^ p;
            chk(got == exp_pat, "R4", $sformatf("sync frame %0d sub %0d", n, sub), got, exp_pat);
            p = halves[sub*64+7];
            w = '0;
            for (int sl = 4; sl < 32; sl++) begin
                h0 = halves[sub*64 + 2*sl];
                h1 = halves[sub*64 + 2*sl + 1];
                if (h0 == p) bmc_bad++;
                w[sl] = h0 ^ h1;
                p = h1;
            end
            chk(bmc_bad == 0, "R3", "missing slot-start transition", bmc_bad, 0);
            s = sub ? r : l;
            field = f ? {s[15:0], 8'h00} : s;
            if (f) chk(w[27:4] == field, "R6 R10", $sformatf("16-bit field frame %0d", n), w[27:4], field);
            else   chk(w[27:4] == field, "R5 R10", $sformatf("24-bit field frame %0d", n), w[27:4], field);
            chk(w[29:28] == 2'b00, "R7", "validity/user", w[29:28], 0);
            chk(w[30] == cs_bits[n], "R8", $sformatf("status bit frame %0d", n), w[30], cs_bits[n]);
            chk(^w[31:4] == 1'b0, "R9", "parity over slots 4..31", ^w[31:4], 0);
            prev_lvl = p;
        end
    endtask

    task automatic t_reset_low();
        sel = 2'b00; bypass_in = 1'b1;
        repeat (3) @(negedge clk);
        chk(tx_out == 1'b0, "R2", "pin in reset, encoder selected", tx_out, 0);
        sel = 2'b01; #1;
        chk(tx_out == 1'b0, "R2", "pin in reset, bypass selected", tx_out, 0);
        sel = 2'b00;
    endtask

    task automatic t_stream();
        logic [23:0] cl = '0, cr = '0, pl, pr;
        bit cf = 0, pf;
        @(negedge clk); rst = 1'b0;
        prev_lvl = 1'b0;
        for (int n = 0; n < FRAMES + 2; n++) begin
            pl = 24'hC3A51E ^ 24'(n * 24'h010203);
            pr = ~pl ^ 24'(n);
            pf = ((n % 4) >= 2);
            capture_frame(1'b1, pl, pr, pf);
            decode_check(n % FRAMES, cl, cr, cf);
            cl = pl; cr = pr; cf = pf;
        end
    endtask

    task automatic t_bypass();
        for (int c = 1; c < 4; c++) begin
            sel = 2'(c);
            for (int v = 0; v < 2; v++) begin
                @(negedge clk); bypass_in = v[0]; #1;
                chk(tx_out == v[0], "R1", $sformatf("bypass sel=%0d", c), tx_out, v[0]);
            end
        end
    endtask

    task automatic t_reselect();
        @(negedge clk); rst = 1'b1; sel = 2'b01; bypass_in = 1'b1;
        repeat (3) @(negedge clk);
        chk(tx_out == 1'b0, "R2", "pin low during second reset", tx_out, 0);
        sel = 2'b00; fmt16 = 1'b0;
        rst = 1'b0;
        prev_lvl = 1'b0;
        capture_frame(1'b0, '0, '0, 1'b0);
        decode_check(0, '0, '0, 1'b0);
        chk(halves[0] == 1'b1, "R1", "encoder drives pin after reselect", halves[0], 1);
    endtask

    initial begin
        for (int i = 0; i < FRAMES; i++) cs_bits[i] = ((i % 3) == 0) ^ ((i % 7) == 1);
        t_reset_low();
        t_stream();
        t_bypass();
        t_reselect();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(150000 * 5);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule